// File: doc/BRIEF.md
# Debounced Input Change Detector

This block watches a small group of asynchronous input lines and remembers which of them have changed level. Each line first passes through a two-stage synchronizer. A free-running divider turns the system clock into a slow sample tick. On each tick the block samples every line. A line's accepted level moves to a new value only when two consecutive ticks have both seen that value. Each accepted move, whether rising or falling, sets a sticky change flag for that line.

Software reads one status word that holds the change flags and the accepted levels. That read also clears the flags. If a line confirms a new change in the same clock cycle as a read, its flag stays set, so the change is not lost. An interrupt request goes high while any change flag is set whose line is enabled in a mask. Bus decode lies outside the block: the read strobe and the mask arrive as plain pins.

The default divider value gives a tick of about 38.4 kHz from a 50 MHz clock. Under that setting, a pulse shorter than one tick period (about 26 µs) is always rejected. A level held for two tick periods plus a few clocks is always recorded.

Top module: `line_change_watch`

## Requirements
- R1: While reset is held and after it is released, the accepted levels equal the synchronized inputs. All change flags read 0 and `irq` is low.
- R2: A low-to-high move on a line that is held long enough sets that line's change flag. The accepted level becomes 1.
- R3: A high-to-low move on a line that is held long enough sets that line's change flag. The accepted level becomes 0.
- R4: A pulse shorter than TICK_DIV clock cycles, after which the line returns to its accepted level, changes neither the accepted level nor the change flag.
- R5: A new level held for at least 2*TICK_DIV+3 clock cycles is always accepted within that time.
- R6: `rd_data` bit 4+i is the change flag of line i. Bit i is the accepted level of line i.
- R7: A cycle with `rd_en` high clears every change flag at the following clock edge.
- R8: A change confirmed in the same cycle as a read leaves its flag set after that read.
- R9: `irq` is high exactly when some line i has its change flag set and `irq_mask[i]` is 1.
- R10: Change flags stay set until read, even if the line later moves back to its earlier level. The accepted level follows the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | NUM_LINES | Asynchronous lines to watch |
| rd_en | input | 1 | Status read strobe; clears the change flags |
| irq_mask | input | NUM_LINES | Per-line interrupt enable, 1 = enabled |
| rd_data | output | 2*NUM_LINES | Change flags (upper half) and accepted levels (lower half) |
| irq | output | 1 | Interrupt request |

## Verification
A wrong accepted level or a wrong filter history appears in the lower half of `rd_data`. It can take up to two tick periods to show, because a missed or false confirmation only surfaces at the tick that decides it. A change flag that is set or cleared wrongly shows in the upper half and on `irq`. A flag dropped by a read that coincides with a confirmation is caught by reading on every cycle, which must show that flag exactly once. A glitch that gets through shows as a flag set on a line whose level did not move.

// File: rtl/lcw_pkg.sv
package lcw_pkg;
  localparam int LCW_LINES = 4;
  localparam int LCW_TICK_DIV = 1302;

  typedef struct packed {
    logic level;
    logic hit;
  } lcw_filt_t;
endpackage

// File: rtl/lcw_sync.sv
module lcw_sync #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic stage1, stage2;
    always_ff @(posedge clk) begin
      stage1 <= async_in[g];
      stage2 <= stage1;
    end
    assign sync_out[g] = stage2;
  end
endmodule

// File: rtl/lcw_tick.sv
module lcw_tick #(
  parameter int DIV = 1302
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);

  if (DIV > 1) begin : g_chk
    assert_tick_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
  end
endmodule

// File: rtl/lcw_filter.sv
module lcw_filter
  import lcw_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      s_in,
  output lcw_filt_t st
);
  logic prev_q, level_q, accept;

  assign accept = tick && (s_in == prev_q) && (s_in != level_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q  <= s_in;
      level_q <= s_in;
    end else if (tick) begin
      prev_q <= s_in;
      if (accept) level_q <= s_in;
    end
  end

  assign st.level = level_q;
  assign st.hit   = accept;

  assert_level_moves_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && level_q != $past(level_q)) |-> $past(tick));
endmodule

// File: rtl/line_change_watch.sv
module line_change_watch
  import lcw_pkg::*;
#(
  parameter int NUM_LINES = LCW_LINES,
  parameter int TICK_DIV  = LCW_TICK_DIV
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_LINES-1:0]   line_in,
  input  logic                   rd_en,
  input  logic [NUM_LINES-1:0]   irq_mask,
  output logic [2*NUM_LINES-1:0] rd_data,
  output logic                   irq
);
  logic [NUM_LINES-1:0] synced, level, hit, chg_q;
  logic                 tick;

  lcw_sync #(.WIDTH(NUM_LINES)) u_sync (
    .clk(clk), .async_in(line_in), .sync_out(synced));

  lcw_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick));

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_filt
    lcw_filt_t st;
    lcw_filter u_filt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .s_in(synced[g]), .st(st));
    assign level[g] = st.level;
    assign hit[g]   = st.hit;

    assert_flag_rise_has_move_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $rose(chg_q[g])) |-> (level[g] != $past(level[g])));
    assert_flag_clear_by_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $fell(chg_q[g])) |-> $past(rd_en));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) chg_q <= '0;
    else        chg_q <= (rd_en ? '0 : chg_q) | hit;
  end

  assign rd_data = {chg_q, level};
  assign irq     = |(chg_q & irq_mask);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (chg_q == '0));
endmodule

// File: tb/line_change_watch_tb.sv
module line_change_watch_tb;
  localparam int DIV  = 8;
  localparam int HOLD = 2 * DIV + 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] line_in = 4'b1010;
  logic       rd_en = 1'b0;
  logic [3:0] irq_mask = 4'h0;
  logic [7:0] rd_data;
  logic       irq;

  int checks = 0;
  int errors = 0;
  logic [3:0] lvl_exp, chg_exp;

  always #10 clk = ~clk;

  line_change_watch #(.NUM_LINES(4), .TICK_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .rd_en(rd_en),
    .irq_mask(irq_mask), .rd_data(rd_data), .irq(irq));

  function automatic logic exp_irq(logic [3:0] c, logic [3:0] m);
    return |(c & m);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_hold();
    for (int c = 0; c < HOLD; c++) @(negedge clk);
  endtask

  task automatic do_read(string req);
    @(negedge clk);
    rd_en = 1'b1;
    chk(req, rd_data, {chg_exp, lvl_exp});
    chg_exp = 4'h0;
    @(negedge clk);
    rd_en = 1'b0;
    chk("R7 flags clear after read", rd_data[7:4], 4'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int hits;
    logic [3:0] tog, glt;
    int glen [4];
    void'($urandom(32'd20240611));
    repeat (6) @(negedge clk);
    irq_mask = 4'hF;
    chk("R1 reset levels/flags", rd_data, 8'h0A);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", rd_data, 8'h0A);
    chk("R1 irq low", irq, 1'b0);
    lvl_exp = 4'b1010;
    chg_exp = 4'h0;

    // R2 rising on line 0, R3 falling on line 1
    line_in[0] = 1'b1; line_in[1] = 1'b0;
    lvl_exp = 4'b1001; chg_exp = 4'b0011;
    wait_hold();
    chk("R2 rise level", rd_data[0], 1'b1);
    chk("R3 fall level", rd_data[1], 1'b0);
    chk("R2/R3 flags", rd_data[7:4], 4'b0011);
    chk("R9 irq all enabled", irq, 1'b1);
    irq_mask = 4'b1100;
    @(negedge clk);
    chk("R9 irq masked", irq, 1'b0);
    do_read("R6 read word layout");

    // R4 glitch of DIV-1 cycles on line 2
    line_in[2] = ~line_in[2];
    for (int c = 0; c < DIV - 1; c++) @(negedge clk);
    line_in[2] = ~line_in[2];
    wait_hold();
    chk("R4 glitch rejected", rd_data, {4'h0, lvl_exp});

    // R10 sticky across a return to the old level
    line_in[3] = 1'b0; wait_hold();
    line_in[3] = 1'b1; wait_hold();
    chg_exp = 4'b1000;
    chk("R10 sticky flag and level", rd_data, {chg_exp, lvl_exp});
    do_read("R10 read");

    // R8 read on every cycle while a change confirms
    hits = 0;
    line_in[0] = 1'b0;
    lvl_exp[0] = 1'b0;
    rd_en = 1'b1;
    for (int c = 0; c < HOLD; c++) begin
      @(negedge clk);
      if (rd_data[4]) hits++;
    end
    rd_en = 1'b0;
    chk("R8 confirmed flag seen once", hits, 1);
    @(negedge clk);
    chk("R8 level", rd_data, {4'h0, lvl_exp});

    // random mix: holds, glitches, idle lines
    for (int step = 0; step < 40; step++) begin
      irq_mask = 4'($urandom % 16);
      tog = 4'h0; glt = 4'h0;
      for (int i = 0; i < 4; i++) begin
        int op;
        op = $urandom % 3;
        glen[i] = 0;
        if (op == 1) tog[i] = 1'b1;
        else if (op == 2) begin
          glt[i] = 1'b1;
          glen[i] = 1 + ($urandom % (DIV - 1));
        end
      end
      @(negedge clk);
      line_in = line_in ^ tog ^ glt;
      lvl_exp = lvl_exp ^ tog;
      chg_exp = chg_exp | tog;
      for (int c = 1; c < HOLD; c++) begin
        @(negedge clk);
        for (int i = 0; i < 4; i++)
          if (glt[i] && c == glen[i]) line_in[i] = ~line_in[i];
      end
      chk("R5 accepted levels", rd_data[3:0], lvl_exp);
      chk("R4/R10 change flags", rd_data[7:4], chg_exp);
      chk("R9 irq", irq, exp_irq(chg_exp, irq_mask));
      if (step % 3 == 2) do_read("R6/R7 random read");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule